// File: doc/BRIEF.md
# Wait-Instruction Trap Router

This unit sits in a processor core's execute stage and decides the fate of a wait-for-interrupt or wait-for-event instruction. When the instruction is presented for one cycle, the unit looks at the current privilege level, the security state, the register width of level 1, the implemented-feature flags and the per-level trap-control bits. From these it chooses whether a more privileged level wants to intercept the instruction.

If a trap is chosen, the unit raises a one-cycle trap request with the target level, an undefined-class syndrome word and a program counter rewound by one instruction, so that returning from the exception re-executes the wait. If no level intercepts, a wait-for-interrupt puts the core into a registered halted state until the wake input rises, and a wait-for-event only produces a single-cycle yield pulse.

Top module: `wfx_trap_router`

## Requirements
- R1: Only levels strictly greater than `cur_level` can be trap targets; `trap_level` encodes the target as 1, 2 or 3, and a level-3 core never traps.
- R2: A level-1 trap is taken when the active-low not-trap bit for the executed kind is 0 (`l1_ntrap_wfi` for wait-for-interrupt, `l1_ntrap_wfe` for wait-for-event); the other kind's bit has no effect.
- R3: When `l1_narrow` is 1, the level-1 bits are honoured only if `feat_v8` is 1, in secure and non-secure state alike.
- R4: A level-2 trap needs `feat_l2` = 1, `secure` = 0 and the level-2 trap bit for the kind set to 1.
- R5: A level-3 trap needs `feat_l3` = 1, `feat_v8` = 1 and the level-3 trap bit for the kind set to 1.
- R6: When several levels are eligible, level 1 wins over level 2 and level 2 over level 3.
- R7: `trap_valid`, `trap_level`, `trap_syndrome` and `trap_pc` are registered: `trap_valid` is high exactly in the cycle after the accepted strobe and low in the cycle after that unless a new strobe traps.
- R8: The syndrome is 32 bits: [31:26] = 6'h01, [25] = 1 (length), [24] = 1 (condition valid), [23:20] = 4'hE, [19:1] = 0, [0] = 1 for wait-for-event and 0 for wait-for-interrupt (0x07E00000 or 0x07E00001).
- R9: `trap_pc` equals `pc_in` minus 4 (modulo 2^PC_W) as sampled with the strobe.
- R10: An untrapped wait-for-interrupt sets `halted` in the cycle after the strobe; `halted` stays 1 until a clock edge samples `wake` at 1 after having sampled it at 0 on the previous edge, and is 0 from that edge on.
- R11: An untrapped wait-for-event raises `yield` for exactly one cycle after the strobe and does not set `halted`.
- R12: A strobe that arrives while `halted` is 1 is ignored: no trap, no yield, and `halted` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | One-cycle strobe: a wait instruction executes |
| instr_is_event | input | 1 | 1 = wait-for-event, 0 = wait-for-interrupt |
| cur_level | input | 2 | Current privilege level 0..3 |
| secure | input | 1 | 1 = secure state |
| l1_narrow | input | 1 | Level 1 runs in 32-bit register mode |
| feat_v8 | input | 1 | Newer-architecture feature present |
| feat_l2 | input | 1 | Level 2 implemented |
| feat_l3 | input | 1 | Level 3 implemented |
| l1_ntrap_wfi | input | 1 | Level-1 not-trap bit, wait-for-interrupt (active low) |
| l1_ntrap_wfe | input | 1 | Level-1 not-trap bit, wait-for-event (active low) |
| l2_trap_wfi | input | 1 | Level-2 trap bit, wait-for-interrupt |
| l2_trap_wfe | input | 1 | Level-2 trap bit, wait-for-event |
| l3_trap_wfi | input | 1 | Level-3 trap bit, wait-for-interrupt |
| l3_trap_wfe | input | 1 | Level-3 trap bit, wait-for-event |
| wake | input | 1 | Wake request; a rising level ends the halt |
| pc_in | input | PC_W | Program counter of the next instruction |
| trap_valid | output | 1 | Trap request, one cycle |
| trap_level | output | 2 | Target level of the trap |
| trap_syndrome | output | 32 | Exception syndrome word |
| trap_pc | output | PC_W | Rewound program counter |
| halted | output | 1 | Core halted by wait-for-interrupt |
| yield | output | 1 | One-cycle yield after wait-for-event |

## Verification
The assertions assume the strobe is a single-cycle pulse and that all control inputs are steady in the cycle the strobe is high; they relate registered outputs to the inputs sampled one edge earlier. The stimulus changes every input only on the falling clock edge, raises the strobe for exactly one cycle per instruction, and brings the unit back out of halt with a clean low-to-high wake transition before the next table row, except in the directed tests that deliberately hold wake high or strobe while halted.

// File: rtl/wfx_trap_pkg.sv
package wfx_trap_pkg;
  localparam int LVL_W = 2;
  localparam int SYN_W = 32;
  localparam int NUM_LVL = 4;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam logic [5:0] EC_UNDEF = 6'h01;
  localparam logic [3:0] COND_ALWAYS = 4'hE;
  localparam lvl_t LVL_NONE = '0;
endpackage

// File: rtl/wfx_trap_select.sv
module wfx_trap_select
  import wfx_trap_pkg::*;
(
  input  lvl_t cur_level,
  input  logic is_event,
  input  logic secure,
  input  logic l1_narrow,
  input  logic feat_v8,
  input  logic feat_l2,
  input  logic feat_l3,
  input  logic l1_ntrap_wfi,
  input  logic l1_ntrap_wfe,
  input  logic l2_trap_wfi,
  input  logic l2_trap_wfe,
  input  logic l3_trap_wfi,
  input  logic l3_trap_wfe,
  output lvl_t target
);
  logic [NUM_LVL-1:1] above;
  logic [NUM_LVL-1:1] elig;
  logic               l1_bit_n;
  logic               l2_bit;
  logic               l3_bit;

  genvar g;
  generate
    for (g = 1; g < NUM_LVL; g++) begin : g_above
      assign above[g] = (cur_level < lvl_t'(g));
    end
  endgenerate

  always_comb begin
    l1_bit_n = is_event ? l1_ntrap_wfe : l1_ntrap_wfi;
    l2_bit   = is_event ? l2_trap_wfe  : l2_trap_wfi;
    l3_bit   = is_event ? l3_trap_wfe  : l3_trap_wfi;
    elig[1]  = above[1] && !l1_bit_n && (!l1_narrow || feat_v8);
    elig[2]  = above[2] && feat_l2 && !secure && l2_bit;
    elig[3]  = above[3] && feat_l3 && feat_v8 && l3_bit;
  end

  always_comb begin
    target = LVL_NONE;
    for (int k = NUM_LVL - 1; k >= 1; k--) begin
      if (elig[k]) target = lvl_t'(k);
    end
  end

  always_comb begin
    if (target != LVL_NONE) begin
      assert (target > cur_level) else $error("AST_TARGET_ABOVE"); // R1
    end
  end
endmodule

// File: rtl/wfx_syndrome_gen.sv
module wfx_syndrome_gen
  import wfx_trap_pkg::*;
(
  input  logic             is_event,
  output logic [SYN_W-1:0] syndrome
);
  localparam int PAD_W = SYN_W - 6 - 1 - 1 - 4 - 1;

  always_comb begin
    syndrome = {EC_UNDEF, 1'b1, 1'b1, COND_ALWAYS, {PAD_W{1'b0}}, is_event};
  end
endmodule

// File: rtl/wfx_halt_ctrl.sv
module wfx_halt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic wake,
  output logic halted
);
  logic halted_q, halted_d;
  logic wake_q;
  logic wake_rise;

  always_comb begin
    wake_rise = wake && !wake_q;
    halted_d  = halted_q;
    if (halted_q) begin
      if (wake_rise) halted_d = 1'b0;
    end else if (enter) begin
      halted_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      halted_q <= halted_d;
      wake_q   <= wake;
    end
  end

  assign halted = halted_q;

  AST_HALT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !(wake && !wake_q)) |=> halted_q); // R10
  AST_HALT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && wake && !wake_q) |=> !halted_q); // R10
endmodule

// File: rtl/wfx_trap_router.sv
module wfx_trap_router
  import wfx_trap_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic            instr_is_event,
  input  logic [1:0]      cur_level,
  input  logic            secure,
  input  logic            l1_narrow,
  input  logic            feat_v8,
  input  logic            feat_l2,
  input  logic            feat_l3,
  input  logic            l1_ntrap_wfi,
  input  logic            l1_ntrap_wfe,
  input  logic            l2_trap_wfi,
  input  logic            l2_trap_wfe,
  input  logic            l3_trap_wfi,
  input  logic            l3_trap_wfe,
  input  logic            wake,
  input  logic [PC_W-1:0] pc_in,
  output logic            trap_valid,
  output logic [1:0]      trap_level,
  output logic [31:0]     trap_syndrome,
  output logic [PC_W-1:0] trap_pc,
  output logic            halted,
  output logic            yield
);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

  lvl_t             target;
  logic [SYN_W-1:0] syn_now;
  logic             accept;
  logic             do_trap;
  logic             enter_halt;

  logic             trap_valid_q, trap_valid_d;
  lvl_t             trap_level_q, trap_level_d;
  logic [SYN_W-1:0] trap_syn_q, trap_syn_d;
  logic [PC_W-1:0]  trap_pc_q, trap_pc_d;
  logic             yield_q, yield_d;
  logic             load_en;

  wfx_trap_select u_select (
    .cur_level    (cur_level),
    .is_event     (instr_is_event),
    .secure       (secure),
    .l1_narrow    (l1_narrow),
    .feat_v8      (feat_v8),
    .feat_l2      (feat_l2),
    .feat_l3      (feat_l3),
    .l1_ntrap_wfi (l1_ntrap_wfi),
    .l1_ntrap_wfe (l1_ntrap_wfe),
    .l2_trap_wfi  (l2_trap_wfi),
    .l2_trap_wfe  (l2_trap_wfe),
    .l3_trap_wfi  (l3_trap_wfi),
    .l3_trap_wfe  (l3_trap_wfe),
    .target       (target)
  );

  wfx_syndrome_gen u_syn (
    .is_event (instr_is_event),
    .syndrome (syn_now)
  );

  wfx_halt_ctrl u_halt (
    .clk    (clk),
    .rst_n  (rst_n),
    .enter  (enter_halt),
    .wake   (wake),
    .halted (halted)
  );

  always_comb begin
    accept       = instr_valid && !halted;
    do_trap      = accept && (target != LVL_NONE);
    enter_halt   = accept && (target == LVL_NONE) && !instr_is_event;
    load_en      = do_trap;
    trap_valid_d = do_trap;
    yield_d      = accept && (target == LVL_NONE) && instr_is_event;
    trap_level_d = trap_level_q;
    trap_syn_d   = trap_syn_q;
    trap_pc_d    = trap_pc_q;
    if (load_en) begin
      trap_level_d = target;
      trap_syn_d   = syn_now;
      trap_pc_d    = pc_in - PC_STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_valid_q <= 1'b0;
      trap_level_q <= LVL_NONE;
      trap_syn_q   <= '0;
      trap_pc_q    <= '0;
      yield_q      <= 1'b0;
    end else begin
      trap_valid_q <= trap_valid_d;
      trap_level_q <= trap_level_d;
      trap_syn_q   <= trap_syn_d;
      trap_pc_q    <= trap_pc_d;
      yield_q      <= yield_d;
    end
  end

  assign trap_valid    = trap_valid_q;
  assign trap_level    = trap_level_q;
  assign trap_syndrome = trap_syn_q;
  assign trap_pc       = trap_pc_q;
  assign yield         = yield_q;

  AST_TRAP_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (trap_level > $past(cur_level))); // R1
  AST_TRAP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> $past(instr_valid)); // R7
  AST_SYNDROME_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (trap_syndrome[31:20] == 12'h07E && trap_syndrome[19:1] == '0)); // R8
  AST_PC_REWOUND: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (trap_pc == $past(pc_in) - PC_STEP)); // R9
  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    enter_halt |=> halted); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_valid, yield})); // R11
  AST_YIELD_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    yield |-> !halted); // R11
  AST_HALT_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (!trap_valid && !yield)); // R12
endmodule

// File: tb/wfx_trap_router_bench.sv
module wfx_trap_router_bench;
  localparam int PC_W = 32;
  localparam int NV = 13;
  // fields: [15:14] level, 13 secure, 12 narrow, 11 v8, 10 feat_l2, 9 feat_l3,
  // 8 is_event, 7 l1_ntrap_wfi, 6 l1_ntrap_wfe, 5 l2_wfi, 4 l2_wfe, 3 l3_wfi, 2 l3_wfe, [1:0] expected level
  localparam logic [15:0] VECS [NV] = '{
    16'b00_0_0_1_1_1_0_0_1_1_1_1_1_01, // R6 all eligible -> 1
    16'b00_0_0_1_1_1_0_1_1_1_1_1_1_10, // R6 l1 off -> 2
    16'b00_1_0_1_1_1_0_1_1_1_1_1_1_11, // R4 secure blocks l2 -> 3
    16'b00_0_1_0_1_1_0_0_0_0_0_1_1_00, // R3 narrow without v8, R5 no v8
    16'b00_1_1_1_0_0_0_0_0_0_0_0_0_01, // R3 narrow+v8 secure -> 1
    16'b01_0_0_1_1_1_0_0_0_0_0_1_0_11, // R1 at level 1, l1 ignored
    16'b10_0_0_1_1_1_0_0_0_1_1_0_0_00, // R1 at level 2, l2 ignored
    16'b11_0_0_1_1_1_0_0_0_1_1_1_1_00, // R1 at level 3 never traps
    16'b00_0_0_1_1_1_1_0_1_1_0_0_1_11, // R2 event kind uses event bits
    16'b00_0_0_1_0_0_1_1_0_0_0_0_0_01, // R2 event level-1
    16'b00_0_0_1_1_1_1_1_1_1_0_1_0_00, // R11 event no trap
    16'b01_0_0_0_0_1_1_1_1_0_1_0_1_00, // R4 R5 features absent
    16'b01_0_0_1_1_0_1_1_1_0_1_0_0_10  // R4 level-2 event
  };

  logic clk = 1'b0;
  logic rst_n;
  logic instr_valid, instr_is_event, secure, l1_narrow, feat_v8, feat_l2, feat_l3;
  logic [1:0] cur_level;
  logic l1_ntrap_wfi, l1_ntrap_wfe, l2_trap_wfi, l2_trap_wfe, l3_trap_wfi, l3_trap_wfe;
  logic wake;
  logic [PC_W-1:0] pc_in;
  logic trap_valid, halted, yield;
  logic [1:0] trap_level;
  logic [31:0] trap_syndrome;
  logic [PC_W-1:0] trap_pc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  wfx_trap_router #(.PC_W(PC_W)) u_wfx_trap_router (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_is_event(instr_is_event),
    .cur_level(cur_level), .secure(secure), .l1_narrow(l1_narrow), .feat_v8(feat_v8),
    .feat_l2(feat_l2), .feat_l3(feat_l3), .l1_ntrap_wfi(l1_ntrap_wfi),
    .l1_ntrap_wfe(l1_ntrap_wfe), .l2_trap_wfi(l2_trap_wfi), .l2_trap_wfe(l2_trap_wfe),
    .l3_trap_wfi(l3_trap_wfi), .l3_trap_wfe(l3_trap_wfe), .wake(wake), .pc_in(pc_in),
    .trap_valid(trap_valid), .trap_level(trap_level), .trap_syndrome(trap_syndrome),
    .trap_pc(trap_pc), .halted(halted), .yield(yield)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] v);
    cur_level = v[15:14]; secure = v[13]; l1_narrow = v[12]; feat_v8 = v[11];
    feat_l2 = v[10]; feat_l3 = v[9]; instr_is_event = v[8];
    l1_ntrap_wfi = v[7]; l1_ntrap_wfe = v[6]; l2_trap_wfi = v[5]; l2_trap_wfe = v[4];
    l3_trap_wfi = v[3]; l3_trap_wfe = v[2];
  endtask

  task automatic strobe();
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic wake_pulse();
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; instr_valid = 1'b0; wake = 1'b0; pc_in = '0;
    apply(16'h0000);
    repeat (3) @(negedge clk);
    check("reset trap_valid", {63'b0, trap_valid}, 64'd0);
    check("reset halted", {63'b0, halted}, 64'd0);
    check("reset yield", {63'b0, yield}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] exp_lvl;
      logic ev;
      logic [31:0] exp_syn;
      exp_lvl = VECS[i][1:0];
      ev = VECS[i][8];
      exp_syn = 32'h07E0_0000 | {31'b0, ev};
      apply(VECS[i]);
      pc_in = 32'h0000_1000 + 32'(i * 16);
      strobe();
      check($sformatf("R1 R6 row%0d trap_valid", i), {63'b0, trap_valid}, {63'b0, exp_lvl != 2'd0});
      if (exp_lvl != 2'd0) begin
        check($sformatf("R2 R3 R4 R5 R6 row%0d level", i), {62'b0, trap_level}, {62'b0, exp_lvl});
        check($sformatf("R8 row%0d syndrome", i), {32'b0, trap_syndrome}, {32'b0, exp_syn});
        check($sformatf("R9 row%0d pc", i), {32'b0, trap_pc}, {32'b0, pc_in - 32'd4});
      end
      check($sformatf("R11 row%0d yield", i), {63'b0, yield}, {63'b0, exp_lvl == 2'd0 && ev});
      check($sformatf("R10 row%0d halted", i), {63'b0, halted}, {63'b0, exp_lvl == 2'd0 && !ev});
      @(negedge clk);
      check($sformatf("R7 row%0d trap one cycle", i), {63'b0, trap_valid}, 64'd0);
      check($sformatf("R11 row%0d yield one cycle", i), {63'b0, yield}, 64'd0);
      if (exp_lvl == 2'd0 && !ev) begin
        check($sformatf("R10 row%0d halt held", i), {63'b0, halted}, 64'd1);
        wake_pulse();
        check($sformatf("R10 row%0d halt released", i), {63'b0, halted}, 64'd0);
      end
    end

    // R12: strobe while halted is ignored
    apply(16'b11_0_0_1_1_1_0_0_0_0_0_0_0_00);
    strobe();
    check("R10 halt entered", {63'b0, halted}, 64'd1);
    apply(16'b00_0_0_1_1_1_0_0_0_1_1_1_1_00);
    strobe();
    check("R12 no trap while halted", {63'b0, trap_valid}, 64'd0);
    check("R12 halt unchanged", {63'b0, halted}, 64'd1);
    instr_is_event = 1'b1; l1_ntrap_wfe = 1'b1; l2_trap_wfe = 1'b0; l3_trap_wfe = 1'b0;
    strobe();
    check("R12 no yield while halted", {63'b0, yield}, 64'd0);
    wake_pulse();
    check("R10 release after ignore", {63'b0, halted}, 64'd0);

    // R10: wake already high does not release; only a fresh rise does
    wake = 1'b1;
    apply(16'b11_0_0_1_1_1_0_0_0_0_0_0_0_00);
    @(negedge clk);
    strobe();
    check("R10 halt with wake high", {63'b0, halted}, 64'd1);
    @(negedge clk);
    check("R10 level wake no release", {63'b0, halted}, 64'd1);
    wake = 1'b0;
    @(negedge clk);
    check("R10 still halted wake low", {63'b0, halted}, 64'd1);
    wake_pulse();
    check("R10 rise releases", {63'b0, halted}, 64'd0);

    // R9: program counter wrap at zero
    apply(16'b00_0_0_1_0_0_0_0_1_0_0_0_0_01);
    pc_in = '0;
    strobe();
    check("R9 pc wrap", {32'b0, trap_pc}, {32'b0, 32'hFFFF_FFFC});
    check("R8 wfi syndrome", {32'b0, trap_syndrome}, {32'b0, 32'h07E0_0000});

    // R7: back-to-back trapping strobes give consecutive requests
    instr_valid = 1'b1;
    @(negedge clk);
    pc_in = 32'h0000_2000;
    @(negedge clk);
    instr_valid = 1'b0;
    check("R7 back-to-back valid", {63'b0, trap_valid}, 64'd1);
    check("R9 back-to-back pc", {32'b0, trap_pc}, {32'b0, 32'h0000_1FFC});
    @(negedge clk);
    check("R7 drop after burst", {63'b0, trap_valid}, 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule